// File: doc/BRIEF.md
# Legacy PC Reset Controller

This block sits in a chipset's legacy I/O space and turns software writes into one of two kinds of reset: a CPU-only INIT, which restarts the processor and leaves the platform running, or a platform reset, which also clears the chipset's own reset-related registers. Two byte-wide registers are reachable through a small write/read port with a one-bit address select. The first is a reset control register that holds a reset-type selection and starts a reset. The second is a system control port that drives the A20 gate and can also start a CPU reset. A third source is a request line from the keyboard controller, which always maps to a CPU INIT.

A full reset first holds the active-low sleep-state output low for a long interval, set in clock cycles, so that the power rails cycle. The platform reset pulse follows in the same cycle that the sleep output returns high. Both reset outputs are fixed-width pulses. A request that arrives while a pulse is running is absorbed into that pulse. A platform reset always wins over a CPU INIT.

Top module: `pc_reset_ctrl`

## Requirements
- R1: A write to the reset control register (io_sel=0) with data bit 2 set starts a reset and leaves the stored register value unchanged.
- R2: For such a write, a platform reset results when data bit 1 or data bit 3 is set. When both are clear, only a CPU INIT pulse results.
- R3: A write to the reset control register with data bit 2 clear stores data bits 1 and 3. Every other bit of that register reads back as 0.
- R4: A start write with data bit 3 set drives sleep_n low for exactly HOLD_CYC cycles, starting the cycle after the write. The platform reset pulse rises in the same cycle that sleep_n returns high.
- R5: A write to the system control port (io_sel=1) stores the whole byte, which reads back unchanged. a20_gate follows stored bit 1 from the next cycle.
- R6: The system control port starts a CPU INIT only when stored bit 0 changes from 0 to 1. Writing 1 over a stored 1 starts nothing.
- R7: A one-cycle pulse on kbd_rst_req starts a CPU INIT and never a platform reset.
- R8: cpu_init and plat_rst are each high for exactly PULSE_W cycles, starting the cycle after the request. A request during an active pulse does not extend it.
- R9: cpu_init and plat_rst are never high together. A running INIT pulse ends when a platform reset starts. INIT requests made during the sleep hold or during a platform pulse produce no INIT.
- R10: A platform reset clears both registers to 0, which drives a20_gate low. A CPU INIT leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_sel | input | 1 | Register select: 0 reset control, 1 system control port |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data of the selected register |
| kbd_rst_req | input | 1 | CPU reset request from the keyboard controller |
| cpu_init | output | 1 | CPU-only INIT pulse |
| plat_rst | output | 1 | Platform reset pulse |
| sleep_n | output | 1 | Active-low sleep-state power-cycle output |
| a20_gate | output | 1 | A20 gate level |

## Verification
Some internal faults show up at once, on the cycle after the write that triggers them. If the reset-type decode were wrong, the wrong pulse would rise. A missing bit-0 edge detector would produce a second INIT on a repeated write. A register that failed to clear would show a stale read-back value or a20_gate still high after a platform pulse. A wrong pulse or hold counter shows only when the pulse ends, so the bench counts the exact number of high and low cycles and checks the cycle where sleep_n returns high against the rise of plat_rst. A broken priority or merge gate would show as overlapping outputs, as a wrong pulse length, or as an INIT during the hold interval.

// File: rtl/pc_reset_pkg.sv
package pc_reset_pkg;
  localparam int GO_BIT    = 2;
  localparam int SYS_BIT   = 1;
  localparam int FULL_BIT  = 3;
  localparam int A20_BIT   = 1;
  localparam int CPU_BIT   = 0;
  localparam logic [7:0] KEEP_MASK = (8'h1 << SYS_BIT) | (8'h1 << FULL_BIT);

  function automatic logic f_plat_kind(input logic [7:0] d);
    return d[SYS_BIT] | d[FULL_BIT];
  endfunction

  function automatic logic f_full_kind(input logic [7:0] d);
    return d[FULL_BIT];
  endfunction

  function automatic logic [7:0] f_keep(input logic [7:0] d);
    return d & KEEP_MASK;
  endfunction

  function automatic logic f_rising(input logic old_v, input logic new_v);
    return ~old_v & new_v;
  endfunction
endpackage

// File: rtl/pc_reset_regs.sv
module pc_reset_regs
  import pc_reset_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       wr_i,
  input  logic       sel_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       a20_o,
  output logic       go_o,
  output logic       plat_kind_o,
  output logic       full_kind_o,
  output logic       sc_rise_o
);
  logic [7:0] rc_q, sc_q;
  logic       wr_rc, wr_sc;

  assign wr_rc = wr_i & ~sel_i & ~clr_i;
  assign wr_sc = wr_i &  sel_i & ~clr_i;

  assign go_o        = wr_rc & wdata_i[GO_BIT];
  assign plat_kind_o = f_plat_kind(wdata_i);
  assign full_kind_o = f_full_kind(wdata_i);
  assign sc_rise_o   = wr_sc & f_rising(sc_q[CPU_BIT], wdata_i[CPU_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q <= '0;
      sc_q <= '0;
    end else if (clr_i) begin
      rc_q <= '0;
      sc_q <= '0;
    end else begin
      if (wr_rc && !wdata_i[GO_BIT]) rc_q <= f_keep(wdata_i);
      if (wr_sc) sc_q <= wdata_i;
    end
  end

  assign rdata_o = sel_i ? sc_q : rc_q;
  assign a20_o   = sc_q[A20_BIT];

  AST_GO_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> $stable(rc_q)); // R1
  AST_A20_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sc |=> (a20_o == $past(wdata_i[A20_BIT]))); // R5
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (rc_q == 8'h00 && sc_q == 8'h00)); // R10
endmodule

// File: rtl/pc_reset_pulse.sv
module pc_reset_pulse #(
  parameter int PULSE_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic clr_i,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_W + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr_i)              cnt <= '0;
    else if (cnt == '0 && req_i) cnt <= CW'(PULSE_W);
    else if (cnt != '0)          cnt <= cnt - 1'b1;
  end

  assign pulse_o = (cnt != '0);

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(req_i)); // R8
endmodule

// File: rtl/pc_reset_hold.sv
module pc_reset_hold #(
  parameter int HOLD_CYC = 400_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic sleep_n_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  logic [HW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (cnt == '0 && start_i) cnt <= HW'(HOLD_CYC);
    else if (cnt != '0)            cnt <= cnt - 1'b1;
  end

  assign busy_o    = (cnt != '0);
  assign done_o    = (cnt == HW'(1));
  assign sleep_n_o = ~busy_o;

  AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_n_o) |-> $past(start_i)); // R4
endmodule

// File: rtl/pc_reset_ctrl.sv
module pc_reset_ctrl #(
  parameter int PULSE_W  = 16,
  parameter int HOLD_CYC = 400_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic       io_sel,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic       kbd_rst_req,
  output logic       cpu_init,
  output logic       plat_rst,
  output logic       sleep_n,
  output logic       a20_gate
);
  logic go, plat_kind, full_kind, sc_rise;
  logic hold_busy, hold_done;
  logic plat_gate, full_start, plat_direct, plat_fire, plat_event;
  logic init_raw, init_req;

  pc_reset_regs u_regs (
    .clk(clk), .rst_n(rst_n), .clr_i(plat_rst),
    .wr_i(io_wr), .sel_i(io_sel), .wdata_i(io_wdata),
    .rdata_o(io_rdata), .a20_o(a20_gate),
    .go_o(go), .plat_kind_o(plat_kind), .full_kind_o(full_kind),
    .sc_rise_o(sc_rise)
  );

  assign plat_gate   = hold_busy | plat_rst;
  assign full_start  = go & full_kind & ~plat_gate;
  assign plat_direct = go & plat_kind & ~full_kind & ~plat_gate;
  assign plat_fire   = plat_direct | hold_done;
  assign plat_event  = full_start | plat_fire;
  assign init_raw    = (go & ~plat_kind) | sc_rise | kbd_rst_req;
  assign init_req    = init_raw & ~plat_gate & ~plat_event;

  pc_reset_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .start_i(full_start),
    .busy_o(hold_busy), .done_o(hold_done), .sleep_n_o(sleep_n)
  );

  pc_reset_pulse #(.PULSE_W(PULSE_W)) u_plat (
    .clk(clk), .rst_n(rst_n), .req_i(plat_fire), .clr_i(1'b0),
    .pulse_o(plat_rst)
  );

  pc_reset_pulse #(.PULSE_W(PULSE_W)) u_init (
    .clk(clk), .rst_n(rst_n), .req_i(init_req), .clr_i(plat_event),
    .pulse_o(cpu_init)
  );

  AST_INIT_PLAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_init && plat_rst)); // R9
  AST_WAKE_TO_PLAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_n) |-> $rose(plat_rst)); // R4
  AST_KBD_NO_PLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_rst_req && !io_wr && !hold_done) |=> !$rose(plat_rst)); // R7
  AST_NO_INIT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_busy && !cpu_init) |=> !cpu_init); // R9
endmodule

// File: tb/sim_pc_reset_ctrl.sv
module sim_pc_reset_ctrl;
  localparam int PW = 5;
  localparam int HC = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0, io_sel = 1'b0, kbd_rst_req = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic cpu_init, plat_rst, sleep_n, a20_gate;

  int total = 0, bad = 0;
  int n_init, n_plat, n_both, n_sleep;

  always #5 clk = ~clk;

  pc_reset_ctrl #(.PULSE_W(PW), .HOLD_CYC(HC)) u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .kbd_rst_req(kbd_rst_req),
    .cpu_init(cpu_init), .plat_rst(plat_rst), .sleep_n(sleep_n),
    .a20_gate(a20_gate)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr_counts();
    n_init = 0; n_plat = 0; n_both = 0; n_sleep = 0;
  endtask

  task automatic sample();
    if (cpu_init) n_init++;
    if (plat_rst) n_plat++;
    if (cpu_init && plat_rst) n_both++;
    if (!sleep_n) n_sleep++;
  endtask

  task automatic watch(input int n);
    for (int i = 0; i < n; i++) begin
      sample();
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    sample();
    io_sel = sel; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic kick();
    sample();
    kbd_rst_req = 1'b1;
    @(negedge clk);
    kbd_rst_req = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    io_sel = sel;
    #1;
    v = io_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(cpu_init == 0, "R8", "init after reset", cpu_init, 0);
    chk(plat_rst == 0, "R8", "plat after reset", plat_rst, 0);
    chk(sleep_n == 1, "R4", "sleep_n after reset", sleep_n, 1);
    chk(a20_gate == 0, "R5", "a20 after reset", a20_gate, 0);
    rd(1'b0, v); chk(v == 8'h00, "R3", "rc after reset", v, 0);
    rd(1'b1, v); chk(v == 8'h00, "R5", "sc after reset", v, 0);
    @(negedge clk);
  endtask

  task automatic t_store();
    logic [7:0] v;
    wr(1'b0, 8'hFB);
    rd(1'b0, v); chk(v == 8'h0A, "R3", "keep bits 1,3 of FB", v, 8'h0A);
    @(negedge clk);
    wr(1'b0, 8'hF1);
    rd(1'b0, v); chk(v == 8'h00, "R3", "keep bits 1,3 of F1", v, 0);
    @(negedge clk);
  endtask

  task automatic t_init_go();
    logic [7:0] v;
    wr(1'b0, 8'h0A);
    clr_counts();
    wr(1'b0, 8'h04);
    watch(PW + 4);
    chk(n_init == PW, "R2", "init width on go-only", n_init, PW);
    chk(n_plat == 0, "R2", "no plat on go-only", n_plat, 0);
    rd(1'b0, v); chk(v == 8'h0A, "R1", "rc unchanged by go write", v, 8'h0A);
    @(negedge clk);
  endtask

  task automatic t_sys();
    logic [7:0] v;
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h0A);
    chk(a20_gate == 1, "R5", "a20 high before sys reset", a20_gate, 1);
    clr_counts();
    wr(1'b0, 8'h06);
    watch(PW + 4);
    chk(n_plat == PW, "R2", "plat width on sys reset", n_plat, PW);
    chk(n_init == 0, "R2", "no init on sys reset", n_init, 0);
    chk(n_sleep == 0, "R4", "no sleep hold on sys reset", n_sleep, 0);
    chk(a20_gate == 0, "R10", "a20 low after plat", a20_gate, 0);
    rd(1'b0, v); chk(v == 8'h00, "R10", "rc cleared", v, 0);
    rd(1'b1, v); chk(v == 8'h00, "R10", "sc cleared", v, 0);
    @(negedge clk);
  endtask

  task automatic t_full();
    logic [7:0] v;
    wr(1'b1, 8'h02);
    clr_counts();
    wr(1'b0, 8'h0C);
    for (int i = 0; i < HC + PW + 4; i++) begin
      if (i == HC - 1) begin
        chk(sleep_n == 0 && plat_rst == 0, "R4", "last hold cycle sleep_n",
            sleep_n, 0);
      end
      if (i == HC) begin
        chk(sleep_n == 1, "R4", "sleep_n released", sleep_n, 1);
        chk(plat_rst == 1, "R4", "plat rises with release", plat_rst, 1);
      end
      sample();
      @(negedge clk);
    end
    chk(n_sleep == HC, "R4", "hold length", n_sleep, HC);
    chk(n_plat == PW, "R4", "plat width after hold", n_plat, PW);
    chk(n_init == 0, "R2", "no init on full reset", n_init, 0);
    chk(a20_gate == 0, "R10", "a20 low after full", a20_gate, 0);
    rd(1'b1, v); chk(v == 8'h00, "R10", "sc cleared after full", v, 0);
    @(negedge clk);
  endtask

  task automatic t_hold_block();
    clr_counts();
    wr(1'b0, 8'h0C);
    watch(3);
    wr(1'b0, 8'h04);
    kick();
    wr(1'b0, 8'h06);
    watch(HC + PW + 4);
    chk(n_init == 0, "R9", "no init during hold", n_init, 0);
    chk(n_plat == PW, "R9", "single plat after hold", n_plat, PW);
    chk(n_sleep == HC, "R9", "hold not restarted", n_sleep, HC);
  endtask

  task automatic t_sysctl();
    logic [7:0] v;
    clr_counts();
    wr(1'b1, 8'h03);
    chk(a20_gate == 1, "R5", "a20 follows bit1", a20_gate, 1);
    watch(PW + 3);
    chk(n_init == PW, "R6", "init on bit0 rise", n_init, PW);
    chk(n_plat == 0, "R6", "no plat from sc", n_plat, 0);
    rd(1'b1, v); chk(v == 8'h03, "R10", "sc kept after init", v, 8'h03);
    @(negedge clk);
    clr_counts();
    wr(1'b1, 8'h03);
    watch(PW + 3);
    chk(n_init == 0, "R6", "no init on 1 over 1", n_init, 0);
    wr(1'b1, 8'hA2);
    rd(1'b1, v); chk(v == 8'hA2, "R5", "sc whole byte", v, 8'hA2);
    chk(a20_gate == 1, "R5", "a20 still high", a20_gate, 1);
    @(negedge clk);
    clr_counts();
    wr(1'b1, 8'h01);
    chk(a20_gate == 0, "R5", "a20 follows bit1 low", a20_gate, 0);
    watch(PW + 3);
    chk(n_init == PW, "R6", "init on second rise", n_init, PW);
  endtask

  task automatic t_kbd();
    logic [7:0] v;
    clr_counts();
    kick();
    watch(2);
    kick();
    watch(PW + 3);
    chk(n_init == PW, "R8", "merged kbd init width", n_init, PW);
    chk(n_plat == 0, "R7", "kbd gives no plat", n_plat, 0);
    rd(1'b1, v); chk(v == 8'h01, "R10", "sc kept after kbd init", v, 8'h01);
    @(negedge clk);
  endtask

  task automatic t_prio();
    clr_counts();
    kick();
    watch(2);
    wr(1'b0, 8'h06);
    watch(PW + 3);
    chk(n_both == 0, "R9", "init and plat overlap", n_both, 0);
    chk(n_init == 3, "R9", "init cut by plat", n_init, 3);
    chk(n_plat == PW, "R9", "plat full width", n_plat, PW);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store();
    t_init_go();
    t_sys();
    t_full();
    t_hold_block();
    t_sysctl();
    t_kbd();
    t_prio();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule